// File: doc/BRIEF.md
# In-Order Ticketed Request/Acknowledge Monitor

This block watches a single request line and a single acknowledge line and judges whether each request attempt is closed on time by an acknowledge of its own. Several attempts may be outstanding at once. They are served strictly in the order they arrived, so one acknowledge can never close more than one attempt.

Every rising edge of the request line draws the next number from a ticket counter and records the cycle it arrived in a queue of start stamps. The oldest queued attempt is the one being served, and a now-serving counter holds its ticket. An acknowledge is credited only to that attempt. The attempt passes if the acknowledge comes 1 to `MAX_WAIT` cycles after its request edge. It fails once it is older than that. Either way, now-serving steps on and the next attempt takes the head.

The outputs are single-cycle pass and fail pulses carrying the ticket that was resolved. Two error pulses are added: one for an acknowledge that nothing can absorb, and one for a request edge that finds the queue full.

Top module: `ticket_ack_monitor`

## Requirements
- R1: A request attempt is a cycle where `req` is 1 and was 0 in the previous cycle (0 after reset). Holding `req` high opens only one attempt. Each accepted attempt takes the current ticket value, and the ticket counter then steps by one.
- R2: If `ack` is 1 while the head attempt's age is between 1 and `MAX_WAIT` cycles inclusive, the head passes. Age counts cycles since its request edge. `pass_o` pulses and `res_ticket_o` shows that attempt's ticket.
- R3: Once the head attempt reaches age `MAX_WAIT`+1 without having passed, it fails. `fail_o` pulses with its ticket, and it leaves the queue. An `ack` in that cycle is not credited.
- R4: Attempts resolve strictly in arrival order, one per cycle at most. A single `ack` resolves only the head attempt, and younger attempts keep waiting. The resolved ticket numbers form a sequence 0, 1, 2, ... after reset.
- R5: `stray_o` pulses for an `ack` when no attempt is queued, or when the head attempt's age is 0 (including a request edge in the same cycle on an empty queue). Such an `ack` resolves nothing.
- R6: A request edge that finds `DEPTH` attempts queued, with no resolution in the same cycle, pulses `overflow_o`. That attempt is dropped and consumes no ticket. If a resolution happens in that cycle, the edge is accepted.
- R7: The ticket and now-serving counters are `TW` bits wide and wrap modulo 2^`TW`. `res_ticket_o` shows the wrapped value.
- R8: While `rst_n` is 0 at a rising clock edge, the queue is emptied, both counters are zeroed, the request history is cleared and all output pulses are 0.
- R9: All outputs are registered. An event decided from the inputs of one cycle appears on the outputs during the following cycle. `pass_o` and `fail_o` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Request line; rising edges open attempts |
| ack | input | 1 | Acknowledge line |
| pass_o | output | 1 | Head attempt closed in time |
| fail_o | output | 1 | Head attempt timed out |
| res_ticket_o | output | TW | Ticket of the attempt resolved by pass_o/fail_o |
| stray_o | output | 1 | Acknowledge with no eligible attempt |
| overflow_o | output | 1 | Request edge dropped, queue full |

## Verification
The properties assume that `req` and `ack` are clean single-bit levels sampled once per clock. They do not require any fixed spacing between request edges, and they do not require the acknowledge to follow a request. The stimulus drives both lines at the falling clock edge and holds them for a whole cycle. Directed sequences push the queue past its depth and place an acknowledge in the request's own cycle. A seeded random phase then mixes request pulses of varying length with sparse acknowledges, so that every outcome occurs and the ticket counter wraps.

// File: rtl/tkq_pkg.sv
// Shared types for the ticketed request/acknowledge monitor.
// Assumes nothing beyond standard packed structs.
package tkq_pkg;

    // Event flags decided in one cycle and registered onto the outputs.
    typedef struct packed {
        logic pass;
        logic fail;
        logic stray;
        logic ovf;
    } tkq_flags_t;

endpackage

// File: rtl/tkq_edge_det.sv
// Rising-edge detector for the request line.
// Assumes req is synchronous to clk; history clears to 0 on reset.
module tkq_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise
);
    logic sig_q;

    // Remember last cycle's level of the line.
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig;
    end

    assign rise = sig & ~sig_q;
endmodule

// File: rtl/tkq_wrap_ctr.sv
// Free-wrapping counter used for both the ticket and now-serving numbers.
// Assumes wrap modulo 2^W is the intended behaviour.
module tkq_wrap_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] value
);
    // Step by one on request, wrap naturally at the width.
    always_ff @(posedge clk) begin
        if (!rst_n)   value <= '0;
        else if (inc) value <= value + 1'b1;
    end
endmodule

// File: rtl/tkq_stamp_fifo.sv
// Circular queue of start-cycle stamps for pending attempts.
// Assumes the caller never pushes when full without popping, and never pops when empty.
module tkq_stamp_fifo #(
    parameter int DEPTH = 8,
    parameter int SW    = 5,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [SW-1:0]   din,
    input  logic            pop,
    output logic [SW-1:0]   head,
    output logic            empty,
    output logic            full,
    output logic [CNTW-1:0] count
);
    logic [SW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Store the stamp of a newly accepted attempt.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    // Move pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head  = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CNTW'(DEPTH));
endmodule

// File: rtl/ticket_ack_monitor.sv
// Monitor that gives each request edge its own ticket and serves the
// attempts in arrival order. The head attempt passes on an acknowledge
// 1..MAX_WAIT cycles after its edge, and fails when it grows older.
// Assumes req/ack are synchronous levels; all outputs are registered.
module ticket_ack_monitor #(
    parameter int DEPTH    = 8,
    parameter int MAX_WAIT = 10,
    parameter int TW       = 4,
    localparam int SW      = $clog2(MAX_WAIT + DEPTH + 2) + 1,
    localparam int CNTW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          ack,
    output logic          pass_o,
    output logic          fail_o,
    output logic [TW-1:0] res_ticket_o,
    output logic          stray_o,
    output logic          overflow_o
);
    import tkq_pkg::*;

    logic            rise;
    logic [SW-1:0]   cyc_q;
    logic [SW-1:0]   head_stamp;
    logic [SW-1:0]   age;
    logic            empty, full;
    logic [CNTW-1:0] fifo_count;
    logic [TW-1:0]   ticket_val, serving_val;
    logic            in_window, too_old, pop, push_ok;
    tkq_flags_t      now_flags, flags_q;

    tkq_edge_det u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (req),
        .rise (rise)
    );

    // Free-running cycle stamp; ages are differences modulo 2^SW.
    always_ff @(posedge clk) begin
        if (!rst_n) cyc_q <= '0;
        else        cyc_q <= cyc_q + 1'b1;
    end

    tkq_stamp_fifo #(.DEPTH(DEPTH), .SW(SW)) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (push_ok),
        .din  (cyc_q),
        .pop  (pop),
        .head (head_stamp),
        .empty(empty),
        .full (full),
        .count(fifo_count)
    );

    tkq_wrap_ctr #(.W(TW)) u_ticket (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (push_ok),
        .value(ticket_val)
    );

    tkq_wrap_ctr #(.W(TW)) u_serving (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (pop),
        .value(serving_val)
    );

    // Judge the head attempt and the new edge for this cycle.
    always_comb begin
        age       = cyc_q - head_stamp;
        in_window = (age != '0) && (age <= SW'(MAX_WAIT));
        too_old   = (age > SW'(MAX_WAIT));
        now_flags.pass  = ack & ~empty & in_window;
        now_flags.fail  = ~empty & too_old;
        now_flags.stray = ack & (empty | (age == '0));
        pop             = now_flags.pass | now_flags.fail;
        push_ok         = rise & (~full | pop);
        now_flags.ovf   = rise & ~push_ok;
    end

    // Register the event pulses and the resolved ticket.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q      <= '0;
            res_ticket_o <= '0;
        end else begin
            flags_q <= now_flags;
            if (pop) res_ticket_o <= serving_val;
        end
    end

    assign pass_o     = flags_q.pass;
    assign fail_o     = flags_q.fail;
    assign stray_o    = flags_q.stray;
    assign overflow_o = flags_q.ovf;
endmodule

// File: rtl/tkq_checker.sv
// Property checker for ticket_ack_monitor, attached by bind.
// Assumes it sees the monitor's ports plus its counters and occupancy.
module tkq_checker #(
    parameter int DEPTH = 8,
    parameter int TW    = 4,
    parameter int CNTW  = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req,
    input logic            ack,
    input logic            pass_o,
    input logic            fail_o,
    input logic [TW-1:0]   res_ticket_o,
    input logic            stray_o,
    input logic            overflow_o,
    input logic [TW-1:0]   ticket,
    input logic [TW-1:0]   serving,
    input logic [CNTW-1:0] count
);
    logic [TW-1:0] last_q;
    logic          seen_q;

    // Track the last resolved ticket to check the order of service.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0;
            seen_q <= 1'b0;
        end else if (pass_o || fail_o) begin
            last_q <= res_ticket_o;
            seen_q <= 1'b1;
        end
    end

    a_r2_pass_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        pass_o |-> $past(ack));

    a_r5_stray_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        stray_o |-> $past(ack));

    a_r6_overflow_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |-> ($past(req) && $past(count) == CNTW'(DEPTH)));

    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNTW'(DEPTH));

    a_r4_ticket_gap: assert property (@(posedge clk) disable iff (!rst_n)
        TW'(ticket - serving) == TW'(count));

    a_r4_in_order: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_o || fail_o) |-> (res_ticket_o == (seen_q ? TW'(last_q + 1'b1) : '0)));

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_o && fail_o));
endmodule

bind ticket_ack_monitor tkq_checker #(.DEPTH(DEPTH), .TW(TW), .CNTW(CNTW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .ack         (ack),
    .pass_o      (pass_o),
    .fail_o      (fail_o),
    .res_ticket_o(res_ticket_o),
    .stray_o     (stray_o),
    .overflow_o  (overflow_o),
    .ticket      (ticket_val),
    .serving     (serving_val),
    .count       (fifo_count)
);

// File: tb/tb_ticket_ack_monitor.sv
// Self-checking bench: directed corners plus seeded random traffic,
// compared against a queue model built from the requirements.
module tb_ticket_ack_monitor;
    localparam int DEPTH = 4;
    localparam int MAXW  = 10;
    localparam int TW    = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          ack = 1'b0;
    logic          pass_o, fail_o, stray_o, overflow_o;
    logic [TW-1:0] res_ticket_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Model state
    int m_q[$];
    int m_cyc;
    bit m_req_prev;
    int m_serving;

    ticket_ack_monitor #(.DEPTH(DEPTH), .MAX_WAIT(MAXW), .TW(TW)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .ack(ack),
        .pass_o(pass_o), .fail_o(fail_o), .res_ticket_o(res_ticket_o),
        .stray_o(stray_o), .overflow_o(overflow_o)
    );

    always #5 clk = ~clk;

    // Expected {pass, fail, stray, ovf, ticket} for this cycle's inputs.
    function automatic logic [TW+3:0] model_eval(input bit r, input bit a);
        bit rise, valid, p, f, s, o, pop;
        int age;
        rise  = r && !m_req_prev;
        valid = m_q.size() > 0;
        age   = valid ? (m_cyc - m_q[0]) : 0;
        p     = a && valid && age >= 1 && age <= MAXW;
        f     = valid && age > MAXW;
        s     = a && (!valid || age == 0);
        pop   = p || f;
        o     = rise && !(m_q.size() < DEPTH || pop);
        return {p, f, s, o, TW'(m_serving)};
    endfunction

    // Advance the model by one cycle.
    function automatic void model_update(input bit r, input logic [TW+3:0] e);
        bit rise;
        rise = r && !m_req_prev;
        if (e[TW+3] || e[TW+2]) begin
            void'(m_q.pop_front());
            m_serving++;
        end
        if (rise && !e[TW]) m_q.push_back(m_cyc);
        m_cyc++;
        m_req_prev = r;
    endfunction

    task automatic check(input bit ok, input string tag, input string got, input string exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %s expected %s", tag, got, exp);
        end
    endtask

    task automatic step(input bit r, input bit a, input string tag);
        logic [TW+3:0] e;
        bit ok;
        req = r;
        ack = a;
        e = model_eval(r, a);
        model_update(r, e);
        @(negedge clk);
        ok = (pass_o == e[TW+3]) && (fail_o == e[TW+2]) &&
             (stray_o == e[TW+1]) && (overflow_o == e[TW]) &&
             (!(e[TW+3] || e[TW+2]) || res_ticket_o == e[TW-1:0]);
        check(ok, tag,
              $sformatf("p%0b f%0b s%0b o%0b t%0d", pass_o, fail_o, stray_o, overflow_o, res_ticket_o),
              $sformatf("p%0b f%0b s%0b o%0b t%0d", e[TW+3], e[TW+2], e[TW+1], e[TW], e[TW-1:0]));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req = 1'b0;
        ack = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_q.delete();
        m_cyc = 0;
        m_req_prev = 0;
        m_serving = 0;
        check(!pass_o && !fail_o && !stray_o && !overflow_o, "R8 reset state",
              $sformatf("p%0b f%0b s%0b o%0b", pass_o, fail_o, stray_o, overflow_o), "all 0");
    endtask

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd1234);

        // R2: single attempt acknowledged at age 1
        do_reset();
        step(1, 0, "R2 edge");
        step(0, 1, "R2 pass age1");
        step(0, 0, "R2 idle");

        // R3: no acknowledge -> fail at age MAXW+1; ack at that age not credited
        do_reset();
        step(1, 0, "R3 edge");
        for (int i = 0; i < MAXW - 1; i++) step(0, 0, "R3 wait");
        step(0, 1, "R3 pass at last age");
        step(1, 0, "R3 second edge");
        for (int i = 0; i < MAXW; i++) step(0, 0, "R3 wait2");
        step(0, 1, "R3 fail late ack");
        step(0, 0, "R3 after");

        // R1: held request opens one attempt
        do_reset();
        for (int i = 0; i < 6; i++) step(1, 0, "R1 held high");
        step(1, 1, "R1 one pass");
        step(1, 1, "R1 no second attempt");

        // R4: two pending, one ack resolves only the head
        do_reset();
        step(1, 0, "R4 edge a");
        step(0, 0, "R4 gap");
        step(1, 0, "R4 edge b");
        step(0, 1, "R4 head only");
        for (int i = 0; i < MAXW + 1; i++) step(0, 0, "R4 second fails");

        // R5: stray acknowledges
        do_reset();
        step(0, 1, "R5 empty ack");
        step(1, 1, "R5 age0 ack");
        step(0, 1, "R5 then pass");
        step(0, 1, "R5 stray after pass");

        // R6: overflow at DEPTH pending, edge dropped without ticket
        do_reset();
        for (int i = 0; i < DEPTH + 1; i++) begin
            step(1, 0, "R6 fill edge");
            step(0, 0, "R6 fill gap");
        end
        for (int i = 0; i < DEPTH + 1; i++) step(0, 1, "R6 drain");

        // R8: reset mid-activity empties queue and restarts tickets
        do_reset();
        step(1, 0, "R8 pre edge");
        step(0, 0, "R8 pre gap");
        step(1, 0, "R8 pre edge2");
        do_reset();
        step(0, 1, "R8 ack after reset stray");
        step(1, 0, "R8 edge");
        step(0, 1, "R8 ticket restarts");

        // R7 and R9: random traffic, tickets wrap past 2^TW
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            bit r, a;
            r = ($urandom % 3) == 0;
            a = ($urandom % 4) == 0;
            step(r, a, "R7 R9 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule